// File: doc/BRIEF.md
# Per-Channel Fault Filter and Diagnosis Latch

This block sits between the raw fault indicators of a multi-channel low-side driver and its serial status read-out. Every channel reports four raw fault conditions: overload, over-temperature, open load and short to ground. Overload, open load and short to ground must persist through a programmable number of timebase ticks before they count, while over-temperature is taken at once. Qualified faults are held in sticky per-channel flags until the serial interface reports a completed, valid frame by pulsing `clr_pulse`.

From the sticky flags the block builds a 2-bit priority code per channel, packs the codes into the standard diagnosis word, derives a one-bit-per-channel summary, and drives a shared active-low fault flag that a host can use as an interrupt. Open-load and short-to-ground indications only mean something while the channel is switched off, so they are only filtered while the channel's `chan_off` bit is high.

Each filter is a small state machine with three states: FLT_IDLE (no raw fault), FLT_COUNT (raw fault present, counting ticks) and FLT_HIT (fault has lasted the full filter time). Its transitions are: FLT_IDLE to FLT_COUNT when the raw input rises; FLT_COUNT to FLT_HIT on the tick that completes `FILT_TICKS` counted ticks; FLT_COUNT or FLT_HIT back to FLT_IDLE whenever the raw input is low; otherwise the state holds.

Top module: `diag_latch_top`

## Requirements
- R1: Overload, open-load and short-to-ground faults latch only after the raw input has stayed high through `FILT_TICKS` counted tick strobes after the filter left idle; with `tick` held high the code appears on the (`FILT_TICKS`+2)-th rising clock edge after the raw input is first sampled high, any one-cycle dropout restarts the count, and cycles with `tick` low do not advance it.
- R2: An over-temperature input is latched at the first rising clock edge that samples it high, with no filtering.
- R3: Channel i (counting from 0) occupies bits 2i+1 and 2i of `diag_word`; its code is 11 for no fault, 10 for overload or over-temperature, 01 for open load and 00 for short to ground.
- R4: With several latched faults on one channel, code 10 wins over 00, and 00 wins over 01.
- R5: Open-load and short-to-ground inputs are ignored while the channel's `chan_off` bit is 0; the code stays 11.
- R6: A latched fault stays in `diag_word` after its raw input drops, until `clr_pulse` is seen.
- R7: On a clock edge with `clr_pulse` high, every flag whose raw fault is absent is cleared; a fault still present at that edge (over-temperature, or a filtered fault that is still qualified) stays latched.
- R8: `diag_bit[i]` is 1 when channel i's code is 11 and 0 otherwise.
- R9: `fault_n` is 0 exactly when at least one channel holds a latched fault.
- R10: After reset, `diag_word` is all ones, `diag_bit` is all ones and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe that advances the filters |
| raw_ovl | input | NCH | Raw overload indication per channel |
| raw_otemp | input | NCH | Raw over-temperature indication per channel |
| raw_open | input | NCH | Raw open-load indication per channel |
| raw_short | input | NCH | Raw short-to-ground indication per channel |
| chan_off | input | NCH | 1 while the channel is commanded off |
| clr_pulse | input | 1 | One-cycle clear from a completed valid serial frame |
| diag_word | output | 2*NCH | Packed 2-bit diagnosis codes |
| diag_bit | output | NCH | One-bit diagnosis, 1 = no fault |
| fault_n | output | 1 | Shared fault flag, low while any fault is latched |

## Verification
A filtered fault reaches the outputs `FILT_TICKS`+2 edges after the raw input is first sampled (one edge to leave idle, `FILT_TICKS` counting edges, one edge into the latch), an over-temperature fault one edge after it is sampled, and a clear takes effect at the edge that samples `clr_pulse`; the outputs are combinational from the latches. The bench drives inputs on falling edges and samples on falling edges. The table holds each vector for eight edges, well past the filter latency. The directed tests probe the exact latency edge: they check that the code is still 11 one edge before the expected edge and present on that edge, with ticks running, with a dropout and with ticks paused.

// File: rtl/diag_latch_pkg.sv
package diag_latch_pkg;

    typedef enum logic [1:0] {
        FLT_IDLE  = 2'd0,
        FLT_COUNT = 2'd1,
        FLT_HIT   = 2'd2
    } flt_state_t;

    localparam logic [1:0] CODE_SHORT = 2'b00;
    localparam logic [1:0] CODE_OPEN  = 2'b01;
    localparam logic [1:0] CODE_PROT  = 2'b10;
    localparam logic [1:0] CODE_OK    = 2'b11;

endpackage

// File: rtl/fault_filter.sv
module fault_filter
    import diag_latch_pkg::*;
#(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic qual
);
    localparam int CW = $clog2(FILT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_TICKS - 1);

    flt_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            FLT_IDLE: begin
                cnt_nx = '0;
                if (raw) state_nx = FLT_COUNT;
            end
            FLT_COUNT: begin
                if (!raw) begin
                    state_nx = FLT_IDLE;
                    cnt_nx   = '0;
                end else if (tick) begin
                    if (cnt == LAST) state_nx = FLT_HIT;
                    else             cnt_nx   = cnt + 1'b1;
                end
            end
            FLT_HIT: begin
                if (!raw) begin
                    state_nx = FLT_IDLE;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = FLT_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLT_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb qual = (state == FLT_HIT) && raw;

endmodule

// File: rtl/chan_diag.sv
module chan_diag
    import diag_latch_pkg::*;
#(
    parameter int FILT_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ovl,
    input  logic       otemp,
    input  logic       open_ld,
    input  logic       short_gnd,
    input  logic       off,
    input  logic       clr,
    output logic [1:0] code,
    output logic       flagged
);
    logic [2:0] raw_f;
    logic [2:0] qual_f;

    // filtered sources: 0 overload, 1 open load, 2 short to ground
    always_comb begin
        raw_f[0] = ovl;
        raw_f[1] = open_ld & off;
        raw_f[2] = short_gnd & off;
    end

    for (genvar k = 0; k < 3; k++) begin : g_flt
        fault_filter #(.FILT_TICKS(FILT_TICKS)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .raw  (raw_f[k]),
            .qual (qual_f[k])
        );
    end

    logic lat_ovl, lat_ot, lat_ol, lat_sg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_ovl <= 1'b0;
            lat_ot  <= 1'b0;
            lat_ol  <= 1'b0;
            lat_sg  <= 1'b0;
        end else begin
            lat_ovl <= (lat_ovl & ~clr) | qual_f[0];
            lat_ot  <= (lat_ot  & ~clr) | otemp;
            lat_ol  <= (lat_ol  & ~clr) | qual_f[1];
            lat_sg  <= (lat_sg  & ~clr) | qual_f[2];
        end
    end

    always_comb begin
        if (lat_ovl || lat_ot) code = CODE_PROT;
        else if (lat_sg)       code = CODE_SHORT;
        else if (lat_ol)       code = CODE_OPEN;
        else                   code = CODE_OK;
        flagged = lat_ovl | lat_ot | lat_ol | lat_sg;
    end

endmodule

// File: rtl/diag_latch_top.sv
module diag_latch_top #(
    parameter int NCH        = 4,
    parameter int FILT_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NCH-1:0]   raw_ovl,
    input  logic [NCH-1:0]   raw_otemp,
    input  logic [NCH-1:0]   raw_open,
    input  logic [NCH-1:0]   raw_short,
    input  logic [NCH-1:0]   chan_off,
    input  logic             clr_pulse,
    output logic [2*NCH-1:0] diag_word,
    output logic [NCH-1:0]   diag_bit,
    output logic             fault_n
);
    localparam int DW = 2 * NCH;

    logic [DW-1:0]  codes;
    logic [NCH-1:0] flags;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_diag #(.FILT_TICKS(FILT_TICKS)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .ovl      (raw_ovl[i]),
            .otemp    (raw_otemp[i]),
            .open_ld  (raw_open[i]),
            .short_gnd(raw_short[i]),
            .off      (chan_off[i]),
            .clr      (clr_pulse),
            .code     (codes[2*i +: 2]),
            .flagged  (flags[i])
        );
    end

    always_comb begin
        diag_word = codes;
        for (int i = 0; i < NCH; i++) diag_bit[i] = &codes[2*i +: 2];
        fault_n = ~|flags;
    end

endmodule

// File: rtl/diag_latch_chk.sv
module diag_latch_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   raw_ovl,
    input logic [NCH-1:0]   raw_otemp,
    input logic [NCH-1:0]   raw_open,
    input logic [NCH-1:0]   raw_short,
    input logic             clr_pulse,
    input logic [2*NCH-1:0] diag_word,
    input logic [NCH-1:0]   diag_bit,
    input logic             fault_n
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R2: over-temperature shows as protection code after one edge
        a_r2_otemp_next: assert property (@(posedge clk) disable iff (!rst_n)
            raw_otemp[i] |=> diag_word[2*i +: 2] == 2'b10);
        // R6: a fault stays latched without a clear
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_pulse && !diag_bit[i]) |=> !diag_bit[i]);
        // R7: clear with no raw fault empties the channel
        a_r7_clear_free: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_pulse && !raw_ovl[i] && !raw_otemp[i] && !raw_open[i] && !raw_short[i])
            |=> diag_bit[i]);
    end

    // R9: shared flag tracks any non-normal code
    a_r9_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n == (diag_word == {2*NCH{1'b1}}));

endmodule

bind diag_latch_top diag_latch_chk #(.NCH(NCH)) u_diag_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_ovl  (raw_ovl),
    .raw_otemp(raw_otemp),
    .raw_open (raw_open),
    .raw_short(raw_short),
    .clr_pulse(clr_pulse),
    .diag_word(diag_word),
    .diag_bit (diag_bit),
    .fault_n  (fault_n)
);

// File: tb/test_diag_latch_top.sv
module test_diag_latch_top;
    localparam int NCH = 4;
    localparam int FT  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic [NCH-1:0] raw_ovl = '0, raw_otemp = '0, raw_open = '0, raw_short = '0, chan_off = '0;
    logic clr_pulse = 1'b0;
    logic [2*NCH-1:0] diag_word;
    logic [NCH-1:0] diag_bit;
    logic fault_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    diag_latch_top #(.NCH(NCH), .FILT_TICKS(FT)) i_diag_latch_top (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .raw_ovl(raw_ovl), .raw_otemp(raw_otemp), .raw_open(raw_open),
        .raw_short(raw_short), .chan_off(chan_off), .clr_pulse(clr_pulse),
        .diag_word(diag_word), .diag_bit(diag_bit), .fault_n(fault_n)
    );

    // ovl, otemp, open, short, off, clr, expected word, requirement tag
    typedef struct packed {
        logic [3:0] ovl;
        logic [3:0] ot;
        logic [3:0] op;
        logic [3:0] sg;
        logic [3:0] off;
        logic       clr;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 8'hFF, 4'd10}, // R10 idle
        '{4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 8'hFE, 4'd3 }, // R3 overload ch0
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 8'hFE, 4'd6 }, // R6 held
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 8'hFF, 4'd7 }, // R7 cleared
        '{4'h0, 4'h0, 4'h2, 4'h0, 4'h2, 1'b0, 8'hF7, 4'd3 }, // R3 open ch1
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 8'hFF, 4'd7 }, // R7
        '{4'h0, 4'h0, 4'h0, 4'h4, 4'h4, 1'b0, 8'hCF, 4'd3 }, // R3 short ch2
        '{4'h0, 4'h0, 4'h4, 4'h4, 4'h4, 1'b0, 8'hCF, 4'd4 }, // R4 short beats open
        '{4'h0, 4'h4, 4'h4, 4'h4, 4'h4, 1'b0, 8'hEF, 4'd4 }, // R4 prot beats short
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 8'hFF, 4'd7 }, // R7
        '{4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 1'b0, 8'hFF, 4'd5 }, // R5 open ignored while on
        '{4'h0, 4'h8, 4'h8, 4'h2, 4'h2, 1'b0, 8'hB3, 4'd2 }, // R2 otemp ch3 + short ch1
        '{4'h0, 4'h8, 4'h8, 4'h0, 4'h2, 1'b1, 8'hBF, 4'd7 }, // R7 present fault survives
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 8'hFF, 4'd7 }  // R7
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] bits_of(input logic [7:0] w);
        logic [NCH-1:0] b;
        for (int i = 0; i < NCH; i++) b[i] = &w[2*i +: 2];
        return b;
    endfunction

    task automatic check(input logic [7:0] exp, input string tag);
        logic [NCH-1:0] eb;
        logic ef;
        eb = bits_of(exp);
        ef = (exp == 8'hFF);
        n_chk++;
        if (diag_word !== exp) begin
            n_bad++;
            $display("FAIL %s diag_word actual %h expected %h", tag, diag_word, exp);
        end
        n_chk++;
        if (diag_bit !== eb) begin
            n_bad++;
            $display("FAIL %s/R8 diag_bit actual %b expected %b", tag, diag_bit, eb);
        end
        n_chk++;
        if (fault_n !== ef) begin
            n_bad++;
            $display("FAIL %s/R9 fault_n actual %b expected %b", tag, fault_n, ef);
        end
    endtask

    task automatic clear_all();
        raw_ovl = '0; raw_otemp = '0; raw_open = '0; raw_short = '0; chan_off = '0;
        clr_pulse = 1'b1;
        step(1);
        clr_pulse = 1'b0;
        step(2);
    endtask

    initial begin
        step(3);
        check(8'hFF, "R10 in reset");
        rst_n = 1'b1;
        step(1);
        check(8'hFF, "R10 after reset");

        for (int v = 0; v < NV; v++) begin
            raw_ovl   = VT[v].ovl;
            raw_otemp = VT[v].ot;
            raw_open  = VT[v].op;
            raw_short = VT[v].sg;
            chan_off  = VT[v].off;
            clr_pulse = VT[v].clr;
            step(1);
            clr_pulse = 1'b0;
            step(7);
            check(VT[v].exp, $sformatf("R%0d vec %0d", VT[v].req, v));
        end

        // R1: exact latency with tick high (FT+2 edges)
        clear_all();
        raw_ovl = 4'h2;
        step(FT + 1);
        check(8'hFF, "R1 early");
        step(1);
        check(8'hFB, "R1 on time");

        // R1: dropout restarts count
        clear_all();
        raw_ovl = 4'h1;
        step(3);
        raw_ovl = 4'h0;
        step(1);
        raw_ovl = 4'h1;
        step(FT + 1);
        check(8'hFF, "R1 dropout early");
        step(1);
        check(8'hFE, "R1 dropout on time");

        // R1: tick low pauses the count
        clear_all();
        tick = 1'b0;
        raw_ovl = 4'h1;
        step(20);
        check(8'hFF, "R1 tick paused");
        tick = 1'b1;
        step(FT);
        check(8'hFF, "R1 resume early");
        step(1);
        check(8'hFE, "R1 resume on time");

        // R2: over-temperature after one edge
        clear_all();
        raw_otemp = 4'h4;
        step(1);
        check(8'hEF, "R2 one edge");
        raw_otemp = 4'h0;

        // R5: short ignored while on, then channel turned on drops filter
        clear_all();
        raw_short = 4'h8;
        chan_off  = 4'h0;
        step(12);
        check(8'hFF, "R5 short while on");

        // R10: reset in mid-run clears latched state
        raw_short = 4'h0;
        raw_otemp = 4'h1;
        step(2);
        raw_otemp = 4'h0;
        rst_n = 1'b0;
        step(1);
        check(8'hFF, "R10 mid-run reset");
        rst_n = 1'b1;
        step(1);
        check(8'hFF, "R10 released");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule